// File: doc/BRIEF.md
# Segmented Virtual Address Mapper

This block decides, for every 32-bit virtual address a core presents, how the address is turned into a physical one. There are three outcomes. If address translation is switched off, the address passes through unchanged with every permission granted. If translation is on and the address falls in a 256 MB segment that is marked for direct mapping, the top nibble is replaced by a per-segment base nibble and the address again gets full permissions. Any other address goes to an external page translator, and the translator's answer is passed back.

Requests come in under a valid/ready handshake. A locally resolved request (pass-through or direct mapping) answers one cycle after it is accepted. A paged request is offered to the translator over its own valid/ready pair. The block then waits, and returns the translator's result in the same cycle that the translator presents it. The configuration and base inputs are sampled in the cycle a request is accepted.

Top module: `seg_mapper`

## Requirements
- R1: Translation is on when bit 2 or bit 3 of `gc_cfg` is set. When it is off, an accepted request answers one cycle later with `rsp_paddr` equal to the virtual address, `rsp_perm` = 3'b111 and `rsp_miss` = 0, and no translator request is raised.
- R2: The segment number is `req_vaddr[31:28]`. When translation is on, the segment is direct-mapped exactly when `mm_cfg[segment]` is 1.
- R3: Segments 0–7 take their base nibble from `kbase_lo` and segments 8–15 from `kbase_hi`, at bits [4·(seg mod 8)+3 : 4·(seg mod 8)].
- R4: A direct-mapped request answers one cycle after acceptance with `rsp_paddr` = {base nibble, vaddr[27:0]}, `rsp_perm` = 3'b111 and `rsp_miss` = 0, and it raises no translator request.
- R5: A paged request (translation on, segment not direct) raises `pt_valid` with `pt_vaddr` equal to the request address. `req_ready` follows `pt_ready`, and no further request is accepted until the translator responds.
- R6: In the cycle where `pt_rsp_valid` is high while a paged request is outstanding, `rsp_valid` is high and `rsp_paddr`, `rsp_perm` and `rsp_miss` equal the translator's values.
- R7: The access type (0 = read, 1 = write, 2 = execute) appears unchanged on `pt_acc`. Permission bits are [0] read, [1] write, [2] execute.
- R8: After reset `rsp_valid` is 0 and the block is idle. With translation off it shows `req_ready` = 1.
- R9: While `pt_valid` is high and `pt_ready` is low, the request stays raised with the same address on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_vaddr | input | 32 | Virtual address |
| req_acc | input | 2 | Access type: 0 read, 1 write, 2 execute |
| gc_cfg | input | 32 | Global configuration; bits 3:2 enable translation |
| mm_cfg | input | 32 | Bits 15:0 mark direct-mapped segments |
| kbase_lo | input | 32 | Base nibbles for segments 0–7 |
| kbase_hi | input | 32 | Base nibbles for segments 8–15 |
| pt_valid | output | 1 | Request to page translator |
| pt_ready | input | 1 | Translator accepts the request |
| pt_vaddr | output | 32 | Address sent to translator |
| pt_acc | output | 2 | Access type sent to translator |
| pt_rsp_valid | input | 1 | Translator result present |
| pt_rsp_paddr | input | 32 | Translator physical address |
| pt_rsp_perm | input | 3 | Translator permissions |
| pt_rsp_miss | input | 1 | Translator miss |
| rsp_valid | output | 1 | Result present |
| rsp_paddr | output | 32 | Physical address |
| rsp_perm | output | 3 | Permissions: [0] read, [1] write, [2] execute |
| rsp_miss | output | 1 | Miss flag |

## Verification
The assertions take for granted that a requester holds its address, access type and configuration steady while `req_valid` waits for `req_ready`. They also assume the translator raises `pt_rsp_valid` only after it has accepted a request. The bench's requester changes inputs only after a handshake completes. Its translator model answers each accepted request once, after a delay that depends on the address. The sweep covers every segment under a disabled setting and under both enable bits, with direct-map masks that place each segment on both sides.

// File: rtl/segmap_pkg.sv
package segmap_pkg;
    localparam int VA_W     = 32;
    localparam int SEG_W    = 4;
    localparam int OFF_W    = VA_W - SEG_W;
    localparam int NSEG     = 1 << SEG_W;
    localparam int NIB_W    = SEG_W;
    localparam int NIB_PER  = VA_W / NIB_W;
    localparam int PERM_W   = 3;
    localparam int ACC_W    = 2;
    localparam int EN_LO    = 2;
    localparam int EN_HI    = 3;
    localparam logic [PERM_W-1:0] PERM_ALL = '1;

    typedef enum logic {ST_IDLE, ST_WAIT} seg_st_e;

    typedef struct packed {
        seg_st_e          st;
        logic             loc_valid;
        logic [VA_W-1:0]  loc_paddr;
    } seg_state_t;
endpackage

// File: rtl/seg_route.sv
module seg_route
    import segmap_pkg::*;
(
    input  logic [VA_W-1:0] vaddr,
    input  logic [31:0]     gc_cfg,
    input  logic [31:0]     mm_cfg,
    input  logic [VA_W-1:0] kbase_lo,
    input  logic [VA_W-1:0] kbase_hi,
    output logic            paged,
    output logic [VA_W-1:0] loc_paddr
);
    logic [NIB_W-1:0] nib_tbl [NSEG];
    logic [SEG_W-1:0] seg;
    logic             xl_on;
    logic             direct;

    generate
        for (genvar g = 0; g < NSEG; g++) begin : g_nib
            if (g < NIB_PER) begin : g_lo
                assign nib_tbl[g] = kbase_lo[g*NIB_W +: NIB_W];
            end else begin : g_hi
                assign nib_tbl[g] = kbase_hi[(g-NIB_PER)*NIB_W +: NIB_W];
            end
        end
    endgenerate

    always_comb begin
        seg       = vaddr[VA_W-1 -: SEG_W];
        xl_on     = |gc_cfg[EN_HI:EN_LO];
        direct    = mm_cfg[seg];
        paged     = xl_on && !direct;
        loc_paddr = xl_on ? {nib_tbl[seg], vaddr[OFF_W-1:0]} : vaddr;
    end
endmodule

// File: rtl/seg_rsp_mux.sv
module seg_rsp_mux
    import segmap_pkg::*;
(
    input  logic              loc_valid,
    input  logic [VA_W-1:0]   loc_paddr,
    input  logic              pt_sel,
    input  logic [VA_W-1:0]   pt_paddr,
    input  logic [PERM_W-1:0] pt_perm,
    input  logic              pt_miss,
    output logic              rsp_valid,
    output logic [VA_W-1:0]   rsp_paddr,
    output logic [PERM_W-1:0] rsp_perm,
    output logic              rsp_miss
);
    always_comb begin
        rsp_valid = loc_valid | pt_sel;
        if (pt_sel) begin
            rsp_paddr = pt_paddr;
            rsp_perm  = pt_perm;
            rsp_miss  = pt_miss;
        end else begin
            rsp_paddr = loc_paddr;
            rsp_perm  = loc_valid ? PERM_ALL : '0;
            rsp_miss  = 1'b0;
        end
    end
endmodule

// File: rtl/seg_mapper.sv
module seg_mapper
    import segmap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic [ACC_W-1:0]  req_acc,
    input  logic [31:0]       gc_cfg,
    input  logic [31:0]       mm_cfg,
    input  logic [VA_W-1:0]   kbase_lo,
    input  logic [VA_W-1:0]   kbase_hi,
    output logic              pt_valid,
    input  logic              pt_ready,
    output logic [VA_W-1:0]   pt_vaddr,
    output logic [ACC_W-1:0]  pt_acc,
    input  logic              pt_rsp_valid,
    input  logic [VA_W-1:0]   pt_rsp_paddr,
    input  logic [PERM_W-1:0] pt_rsp_perm,
    input  logic              pt_rsp_miss,
    output logic              rsp_valid,
    output logic [VA_W-1:0]   rsp_paddr,
    output logic [PERM_W-1:0] rsp_perm,
    output logic              rsp_miss
);
    seg_state_t       state_d, state_q;
    logic             paged;
    logic [VA_W-1:0]  route_paddr;
    logic             pt_sel;

    seg_route u_route (
        .vaddr     (req_vaddr),
        .gc_cfg    (gc_cfg),
        .mm_cfg    (mm_cfg),
        .kbase_lo  (kbase_lo),
        .kbase_hi  (kbase_hi),
        .paged     (paged),
        .loc_paddr (route_paddr)
    );

    always_comb begin
        state_d           = state_q;
        state_d.loc_valid = 1'b0;
        req_ready         = 1'b0;
        pt_valid          = 1'b0;
        pt_vaddr          = req_vaddr;
        pt_acc            = req_acc;
        case (state_q.st)
            ST_IDLE: begin
                if (paged) begin
                    pt_valid  = req_valid;
                    req_ready = pt_ready;
                    if (req_valid && pt_ready)
                        state_d.st = ST_WAIT;
                end else begin
                    req_ready = 1'b1;
                    if (req_valid) begin
                        state_d.loc_valid = 1'b1;
                        state_d.loc_paddr = route_paddr;
                    end
                end
            end
            ST_WAIT: begin
                if (pt_rsp_valid)
                    state_d.st = ST_IDLE;
            end
            default: state_d.st = ST_IDLE;
        endcase
        pt_sel = (state_q.st == ST_WAIT) && pt_rsp_valid;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.st        <= ST_IDLE;
            state_q.loc_valid <= 1'b0;
            state_q.loc_paddr <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    seg_rsp_mux u_mux (
        .loc_valid (state_q.loc_valid),
        .loc_paddr (state_q.loc_paddr),
        .pt_sel    (pt_sel),
        .pt_paddr  (pt_rsp_paddr),
        .pt_perm   (pt_rsp_perm),
        .pt_miss   (pt_rsp_miss),
        .rsp_valid (rsp_valid),
        .rsp_paddr (rsp_paddr),
        .rsp_perm  (rsp_perm),
        .rsp_miss  (rsp_miss)
    );

    AST_OFF_NO_PT: assert property (@(posedge clk) disable iff (!rst_n)
        pt_valid |-> ((|gc_cfg[EN_HI:EN_LO]) && !mm_cfg[req_vaddr[VA_W-1 -: SEG_W]])); // R1
    AST_LOCAL_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.loc_valid |-> (rsp_valid && rsp_perm == PERM_ALL && !rsp_miss)); // R4
    AST_LOCAL_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !pt_valid) |=> (rsp_valid && rsp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0]))); // R4
    AST_WAIT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.st == ST_WAIT) |-> (!req_ready && !pt_valid)); // R5
    AST_PT_PASSBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.st == ST_WAIT && pt_rsp_valid) |-> (rsp_valid && rsp_paddr == pt_rsp_paddr && rsp_miss == pt_rsp_miss)); // R6
    AST_PT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pt_valid && !pt_ready) |=> (pt_valid && $stable(pt_vaddr))); // R9
endmodule

// File: tb/seg_mapper_tb.sv
module seg_mapper_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_acc = '0;
    logic [31:0] gc_cfg = '0;
    logic [31:0] mm_cfg = '0;
    logic [31:0] kbase_lo = 32'h9E3B_47C1;
    logic [31:0] kbase_hi = 32'h2D58_F0A6;
    logic        pt_valid;
    logic        pt_ready = 1'b0;
    logic [31:0] pt_vaddr;
    logic [1:0]  pt_acc;
    logic        pt_rsp_valid = 1'b0;
    logic [31:0] pt_rsp_paddr = '0;
    logic [2:0]  pt_rsp_perm = '0;
    logic        pt_rsp_miss = 1'b0;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic [2:0]  rsp_perm;
    logic        rsp_miss;

    int total = 0;
    int bad = 0;
    int hs_cnt = 0;
    int cyc = 0;
    logic [31:0] cap_va = '0;
    logic [1:0]  cap_acc = '0;
    bit done = 0;

    always #2.5 clk = ~clk;

    seg_mapper u_dut (.*);

    initial forever begin
        @(negedge clk);
        cyc++;
        pt_ready = (cyc % 3) != 0;
    end

    initial forever begin
        @(posedge clk);
        if (pt_valid && pt_ready) begin
            cap_va  = pt_vaddr;
            cap_acc = pt_acc;
            hs_cnt++;
            repeat (1 + int'(cap_va[5:4])) @(negedge clk);
            pt_rsp_valid = 1'b1;
            pt_rsp_paddr = cap_va ^ 32'h0F0F_6000;
            pt_rsp_perm  = {cap_va[14], cap_va[13], 1'b1};
            pt_rsp_miss  = cap_va[12];
            @(negedge clk);
            pt_rsp_valid = 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_req(input logic [31:0] va, input logic [1:0] acc,
                           input bit on, input logic [31:0] cfg);
        int n;
        int hs0;
        bit seg_direct;
        bit exp_paged;
        logic [3:0]  seg;
        logic [3:0]  nib;
        logic [31:0] e_pa;
        logic [2:0]  e_perm;
        logic        e_miss;
        seg = va[31:28];
        seg_direct = cfg[seg];
        exp_paged = on && !seg_direct;
        nib = (seg < 8) ? kbase_lo[4*(seg%8) +: 4] : kbase_hi[4*(seg%8) +: 4];
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_acc = acc; mm_cfg = cfg;
        hs0 = hs_cnt;
        #1;
        n = 0;
        while (!req_ready && n < 100) begin @(negedge clk); #1; n++; end
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        n = 0;
        while (!rsp_valid && n < 100) begin @(negedge clk); #1; n++; end
        if (!on) begin
            e_pa = va; e_perm = 3'b111; e_miss = 1'b0;
        end else if (seg_direct) begin
            e_pa = {nib, va[27:0]}; e_perm = 3'b111; e_miss = 1'b0;
        end else begin
            e_pa = va ^ 32'h0F0F_6000; e_perm = {va[14], va[13], 1'b1}; e_miss = va[12];
        end
        chk(rsp_valid, "R6 response seen", {31'b0, rsp_valid}, 32'd1);
        if (!on) chk(rsp_paddr == e_pa, "R1 passthrough addr", rsp_paddr, e_pa);
        else if (seg_direct) chk(rsp_paddr == e_pa, "R3 R4 direct addr", rsp_paddr, e_pa);
        else chk(rsp_paddr == e_pa, "R6 paged addr", rsp_paddr, e_pa);
        chk(rsp_perm == e_perm, "R4 R6 R7 perm", {29'b0, rsp_perm}, {29'b0, e_perm});
        chk(rsp_miss == e_miss, "R6 miss", {31'b0, rsp_miss}, {31'b0, e_miss});
        chk((hs_cnt - hs0) == (exp_paged ? 1 : 0), "R1 R2 R5 translator use",
            32'(hs_cnt - hs0), exp_paged ? 32'd1 : 32'd0);
        if (exp_paged) begin
            chk(cap_va == va, "R5 pt address", cap_va, va);
            chk(cap_acc == acc, "R7 access type", {30'b0, cap_acc}, {30'b0, acc});
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(rsp_valid == 1'b0, "R8 reset rsp_valid", {31'b0, rsp_valid}, 32'd0);
        chk(req_ready == 1'b1, "R8 reset ready", {31'b0, req_ready}, 32'd1);
        for (int mode = 0; mode < 3; mode++) begin
            gc_cfg = (mode == 0) ? 32'hFFFF_FFF3 : (mode == 1) ? 32'h0000_0004 : 32'h0000_0008;
            for (int pat = 0; pat < 2; pat++) begin
                for (int s = 0; s < 16; s++) begin
                    logic [31:0] va;
                    va = {4'(s), 28'h1234567 ^ (28'(s) * 28'h0111_3130)};
                    run_req(va, 2'(s % 3), mode != 0, pat == 0 ? 32'h0000_A5C3 : 32'hFFFF_5A3C);
                end
            end
        end
        // R9 hold: present a paged request while translator stalls
        gc_cfg = 32'h4; mm_cfg = 32'h0;
        @(negedge clk);
        while (pt_ready) @(negedge clk);
        req_valid = 1'b1; req_vaddr = 32'h3000_0000; req_acc = 2'd1;
        #1;
        chk(pt_valid && pt_vaddr == 32'h3000_0000, "R9 pt raised", pt_vaddr, 32'h3000_0000);
        while (!req_ready) begin @(negedge clk); #1; end
        chk(pt_valid && pt_vaddr == 32'h3000_0000, "R9 pt held", pt_vaddr, 32'h3000_0000);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        while (!rsp_valid) begin @(negedge clk); #1; end
        chk(rsp_paddr == (32'h3000_0000 ^ 32'h0F0F_6000), "R6 hold response", rsp_paddr,
            32'h3000_0000 ^ 32'h0F0F_6000);
        repeat (3) @(negedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule